// File: doc/BRIEF.md
# Zero-Run Destuffing Frame Receiver

This block sits behind a bit-recovery stage and takes one recovered line bit per cycle in which `bit_vld` is high. The line coding inserts a one after every six consecutive zeros so that a transition occurs at least every seven bit times. The receiver strips those inserted ones, finds the start of each frame from a short run of ones, and hands the destuffed header and payload to the next stage as 16-bit words.

A frame on the line is: three ones (the preamble, never stuffed), then a 16-bit header, then the payload words. Header and payload are stuffed. The low ten bits of the header give the number of payload words (0 to 1023). Each word is sent most significant bit first. Frames are separated by at least two idle bits of value zero. A trailing inserted one that follows the last data bit of a frame is seen while hunting and is harmless.

The control is a three-state machine. In `S_HUNT` it counts consecutive valid ones. The transition hunt-to-header is taken on the third one, and any zero restarts the count. In `S_HDR` the sixteenth data bit completes the header word. The transition header-to-hunt is taken when the length is zero, and header-to-payload is taken otherwise. In `S_PAY` each completed word decrements the remaining count. The transition payload-to-hunt is taken on the last word. From either `S_HDR` or `S_PAY`, a stuffing violation takes the transition error-to-hunt.

Top module: `zr_frame_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `word_vld`, `word_hdr`, `word_sof`, `word_eof` and `stuff_err` are 0 and `word_out` is 0.
- R2: Hunting ends only after three consecutive valid ones. A valid zero during hunting restarts the count, so shorter runs of ones before the preamble produce no words and do not shift word alignment.
- R3: Within header and payload, the valid bit that follows six consecutive data zeros is an inserted one. It is discarded and is not counted as data, and the zero count restarts after it. Inserted ones that fall inside the header are removed in the same way.
- R4: If the bit that follows six zeros is a zero, `stuff_err` is high for exactly one cycle, in the cycle after that bit. The frame is abandoned with no further words, and the receiver returns to hunting so that the next frame is received normally.
- R5: Data bits are shifted in MSB first. A word is presented on `word_out` with `word_vld` high for one cycle, in the cycle after its sixteenth data bit.
- R6: The first word after the preamble is the header and is flagged by `word_hdr`=1. Its bits [9:0] give the payload word count.
- R7: On payload words (`word_hdr`=0), `word_sof`=1 marks the first word and `word_eof`=1 marks the last. A one-word payload carries both flags. The flags are 0 on all other words.
- R8: A header with length 0 is delivered with `word_hdr`=1 and `word_eof`=1, and no payload word follows it.
- R9: `bit_in` is ignored in cycles where `bit_vld` is 0. Gaps of any length between valid bits do not change the words delivered.
- R10: A frame of 1023 all-zero payload words, which carries 2728 inserted ones in its payload, is delivered word for word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered line bit |
| bit_vld | input | 1 | `bit_in` holds a new bit this cycle |
| word_out | output | 16 | Destuffed header or payload word |
| word_vld | output | 1 | `word_out` is valid this cycle |
| word_hdr | output | 1 | The word is the frame header |
| word_sof | output | 1 | The word is the first payload word |
| word_eof | output | 1 | The word ends the frame |
| stuff_err | output | 1 | A zero was found where an inserted one was required |

## Verification
The bench encodes frames with its own stuffing encoder and compares every received word and flag against the original data. Zero runs of exactly six and seven bits are placed inside the header and across word boundaries. A design whose zero count does not restart after the inserted one, or that treats the sixth zero itself as the trigger, would slip a bit and corrupt every later word. Runs of one and two ones placed before the preamble would misalign the header if hunting ended early. A deliberate run of seven zeros must give one error pulse with no payload, and the next frame must arrive intact. Zero-length and one-word payloads exercise the end-of-frame flag. Random gaps with random `bit_in` values, and a maximum-length all-zero frame, catch designs that sample bits without a strobe or that have a word counter that is too narrow.

// File: rtl/zr_pkg.sv
package zr_pkg;
    typedef enum logic [1:0] {
        S_HUNT,
        S_HDR,
        S_PAY
    } rx_state_t;
endpackage

// File: rtl/zr_destuff.sv
module zr_destuff #(
    parameter int RUN_MAX = 6,
    localparam int ZW = $clog2(RUN_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_in,
    input  logic          bit_vld,
    output logic          data_bit,
    output logic          data_vld,
    output logic          viol,
    output logic [ZW-1:0] zrun_o
);
    localparam logic [ZW-1:0] RUN_TOP = ZW'(RUN_MAX);
    localparam logic [ZW-1:0] ONE     = ZW'(1);

    logic [ZW-1:0] zrun_q;
    logic          at_stuff;

    assign at_stuff = (zrun_q == RUN_TOP);
    assign zrun_o   = zrun_q;
    assign data_bit = bit_in;

    always_comb begin
        data_vld = 1'b0;
        viol     = 1'b0;
        if (en && bit_vld) begin
            if (at_stuff) begin
                viol = ~bit_in;
            end else begin
                data_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (!en) begin
            zrun_q <= '0;
        end else if (bit_vld) begin
            if (at_stuff || bit_in) begin
                zrun_q <= '0;
            end else begin
                zrun_q <= zrun_q + ONE;
            end
        end
    end
endmodule

// File: rtl/zr_deser.sv
module zr_deser #(
    parameter int W = 16,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         d_bit,
    input  logic         d_vld,
    output logic         word_rdy,
    output logic [W-1:0] word
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    assign word     = {sr_q[W-2:0], d_bit};
    assign word_rdy = d_vld && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (d_vld) begin
            sr_q  <= word;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + ONE;
        end
    end
endmodule

// File: rtl/zr_frame_rx.sv
module zr_frame_rx #(
    parameter int WORD_W  = 16,
    parameter int LEN_W   = 10,
    parameter int RUN_MAX = 6,
    parameter int PRE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              word_hdr,
    output logic              word_sof,
    output logic              word_eof,
    output logic              stuff_err
);
    import zr_pkg::*;

    localparam int ZW = $clog2(RUN_MAX + 1);
    localparam int PW = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;
    localparam logic [PW-1:0]    PRE_TOP = PW'(PRE_LEN - 1);
    localparam logic [PW-1:0]    P_ONE   = PW'(1);
    localparam logic [LEN_W-1:0] L_ONE   = LEN_W'(1);

    rx_state_t         state_q, state_d;
    logic [PW-1:0]     ones_q, ones_d;
    logic [LEN_W-1:0]  rem_q, rem_d;
    logic              first_q, first_d;

    logic              in_frame;
    logic              d_bit, d_vld, viol;
    logic [ZW-1:0]     zrun;
    logic              w_rdy;
    logic [WORD_W-1:0] w_word;

    logic emit, e_hdr, e_sof, e_eof;

    assign in_frame = (state_q != S_HUNT);

    zr_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_frame),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .data_bit (d_bit),
        .data_vld (d_vld),
        .viol     (viol),
        .zrun_o   (zrun)
    );

    zr_deser #(.W(WORD_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~in_frame),
        .d_bit    (d_bit),
        .d_vld    (d_vld),
        .word_rdy (w_rdy),
        .word     (w_word)
    );

    // next-state and event decode
    always_comb begin
        state_d = state_q;
        ones_d  = '0;
        rem_d   = rem_q;
        first_d = first_q;
        emit    = 1'b0;
        e_hdr   = 1'b0;
        e_sof   = 1'b0;
        e_eof   = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                ones_d = ones_q;
                if (bit_vld) begin
                    if (!bit_in) begin
                        ones_d = '0;
                    end else if (ones_q == PRE_TOP) begin
                        ones_d  = '0;
                        state_d = S_HDR;
                    end else begin
                        ones_d = ones_q + P_ONE;
                    end
                end
            end
            S_HDR: begin
                if (viol) begin
                    state_d = S_HUNT;
                end else if (w_rdy) begin
                    emit  = 1'b1;
                    e_hdr = 1'b1;
                    if (w_word[LEN_W-1:0] == '0) begin
                        e_eof   = 1'b1;
                        state_d = S_HUNT;
                    end else begin
                        rem_d   = w_word[LEN_W-1:0];
                        first_d = 1'b1;
                        state_d = S_PAY;
                    end
                end
            end
            S_PAY: begin
                if (viol) begin
                    state_d = S_HUNT;
                end else if (w_rdy) begin
                    emit    = 1'b1;
                    e_sof   = first_q;
                    e_eof   = (rem_q == L_ONE);
                    first_d = 1'b0;
                    rem_d   = rem_q - L_ONE;
                    if (rem_q == L_ONE) begin
                        state_d = S_HUNT;
                    end
                end
            end
            default: begin
                state_d = S_HUNT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HUNT;
            ones_q  <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ones_q  <= ones_d;
            rem_q   <= rem_d;
            first_q <= first_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out  <= '0;
            word_vld  <= 1'b0;
            word_hdr  <= 1'b0;
            word_sof  <= 1'b0;
            word_eof  <= 1'b0;
            stuff_err <= 1'b0;
        end else begin
            if (emit) begin
                word_out <= w_word;
            end
            word_vld  <= emit;
            word_hdr  <= e_hdr;
            word_sof  <= e_sof;
            word_eof  <= e_eof;
            stuff_err <= viol;
        end
    end
endmodule

// File: rtl/zr_frame_rx_chk.sv
module zr_frame_rx_chk #(
    parameter int ZW = 3,
    parameter int RUN_MAX = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_vld,
    input logic          word_vld,
    input logic          word_hdr,
    input logic          word_sof,
    input logic          word_eof,
    input logic          stuff_err,
    input logic [ZW-1:0] zrun
);
    // R7: flags only appear on a delivered word
    p_flags_need_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_hdr || word_sof || word_eof) |-> word_vld);

    // R6: the header is never the first payload word
    p_hdr_not_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_hdr |-> !word_sof);

    // R5: a word takes sixteen data bits, so valid never lasts two cycles
    p_word_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R4: violation is a single-cycle pulse and never coincides with a word
    p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |=> !stuff_err);
    p_err_no_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> !word_vld);

    // R9: without a strobe in the previous cycle nothing is reported
    p_no_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_vld) |-> (!word_vld && !stuff_err));

    // R3: the zero-run counter never passes the stuffing threshold
    p_zrun_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zrun <= ZW'(RUN_MAX));
endmodule

bind zr_frame_rx zr_frame_rx_chk #(.ZW(ZW), .RUN_MAX(RUN_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .word_vld  (word_vld),
    .word_hdr  (word_hdr),
    .word_sof  (word_sof),
    .word_eof  (word_eof),
    .stuff_err (stuff_err),
    .zrun      (zrun)
);

// File: tb/test_zr_frame_rx.sv
module test_zr_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic [15:0] word_out;
    logic        word_vld, word_hdr, word_sof, word_eof, stuff_err;

    int checks = 0;
    int failures = 0;
    int err_seen = 0;
    int err_exp = 0;
    int zr = 0;
    string cur_tag = "R5";
    int unsigned dummy;

    logic        bq[$];
    logic [15:0] pl[$];
    logic [18:0] exp_q[$];

    always #5 clk = ~clk;

    zr_frame_rx i_zr_frame_rx (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .word_out(word_out), .word_vld(word_vld), .word_hdr(word_hdr),
        .word_sof(word_sof), .word_eof(word_eof), .stuff_err(stuff_err)
    );

    // reference stuffing encoder
    task automatic enc_bit(input logic b);
        bq.push_back(b);
        if (b) zr = 0; else zr++;
        if (zr == 6) begin
            bq.push_back(1'b1);
            zr = 0;
        end
    endtask

    task automatic enc_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) enc_bit(w[i]);
    endtask

    task automatic lead_in();
        for (int i = 0; i < 4; i++) bq.push_back(1'b0);
        for (int i = 0; i < 3; i++) bq.push_back(1'b1);
        zr = 0;
    endtask

    task automatic build_frame(input logic [5:0] top);
        logic [15:0] hdr;
        hdr = {top, 10'(pl.size())};
        lead_in();
        enc_word(hdr);
        exp_q.push_back({1'b1, 1'b0, (pl.size() == 0), hdr});
        for (int i = 0; i < pl.size(); i++) begin
            enc_word(pl[i]);
            exp_q.push_back({1'b0, (i == 0), (i == pl.size() - 1), pl[i]});
        end
    endtask

    task automatic send_q(input int gap_pct);
        for (int i = 0; i < bq.size(); i++) begin
            while (($urandom % 100) < gap_pct) begin
                bit_vld = 1'b0;
                bit_in  = 1'($urandom % 2);
                @(posedge clk); #1;
            end
            bit_vld = 1'b1;
            bit_in  = bq[i];
            @(posedge clk); #1;
        end
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        bq.delete();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input logic [5:0] top, input int gap_pct, input string tag);
        cur_tag = tag;
        build_frame(top);
        send_q(gap_pct);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s: words missing actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
        end
        pl.delete();
    endtask

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (stuff_err) err_seen++;
            if (word_vld) begin
                logic [18:0] got, e;
                got = {word_hdr, word_sof, word_eof, word_out};
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL %s: unexpected word actual=%h expected=none", cur_tag, got);
                end else begin
                    e = exp_q.pop_front();
                    if (got != e) begin
                        failures++;
                        $display("FAIL %s (hdr R6, sof/eof R7): actual=%h expected=%h",
                                 cur_tag, got, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        dummy = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        #1;
        checks++; // R1 during reset
        if ({word_vld, word_hdr, word_sof, word_eof, stuff_err} != 5'b0 || word_out != 16'h0) begin
            failures++;
            $display("FAIL R1: actual=%b/%h expected=0/0",
                     {word_vld, word_hdr, word_sof, word_eof, stuff_err}, word_out);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        checks++; // R1 after release
        if ({word_vld, word_hdr, word_sof, word_eof, stuff_err} != 5'b0 || word_out != 16'h0) begin
            failures++;
            $display("FAIL R1: actual=%b/%h expected=0/0",
                     {word_vld, word_hdr, word_sof, word_eof, stuff_err}, word_out);
        end

        // R3: header begins with long zero runs; runs of six and seven in payload
        pl.push_back(16'h0381); pl.push_back(16'h03F0); pl.push_back(16'h8000);
        pl.push_back(16'h0040);
        run_frame(6'h00, 0, "R3");

        // R5: all ones and an MSB-first pattern
        pl.push_back(16'hFFFF); pl.push_back(16'h8001); pl.push_back(16'h1234);
        run_frame(6'h3F, 0, "R5");

        // R8: header-only frame
        run_frame(6'h2A, 0, "R8");

        // R7: one-word payload carries both sof and eof
        pl.push_back(16'hA5C3);
        run_frame(6'h15, 10, "R7");

        // R2: short runs of ones before the preamble
        cur_tag = "R2";
        bq.push_back(1'b0); bq.push_back(1'b1); bq.push_back(1'b0);
        bq.push_back(1'b1); bq.push_back(1'b1); bq.push_back(1'b0);
        pl.push_back(16'h7E00); pl.push_back(16'h0001);
        run_frame(6'h07, 0, "R2");

        // R4: seven zeros without the inserted one, then a good frame
        cur_tag = "R4";
        lead_in();
        enc_word(16'h8005);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 16'h8005});
        for (int i = 0; i < 15; i++) bq.push_back(1'b0);
        err_exp++;
        send_q(0);
        checks++;
        if (err_seen != err_exp) begin
            failures++;
            $display("FAIL R4: stuff_err pulses actual=%0d expected=%0d", err_seen, err_exp);
        end
        exp_q.delete();
        pl.push_back(16'hC0DE); pl.push_back(16'h0000);
        run_frame(6'h01, 0, "R4");

        // R9: heavy gaps with random bit_in while invalid
        for (int i = 0; i < 20; i++) pl.push_back(16'($urandom));
        run_frame(6'h0C, 60, "R9");

        // constrained random frames
        for (int f = 0; f < 8; f++) begin
            int n;
            n = int'($urandom % 41);
            for (int i = 0; i < n; i++) begin
                if (($urandom % 4) == 0) pl.push_back(16'h0000);
                else pl.push_back(16'($urandom));
            end
            run_frame(6'($urandom), int'($urandom % 40), "R5");
        end

        // R10: maximum length, all zeros
        for (int i = 0; i < 1023; i++) pl.push_back(16'h0000);
        run_frame(6'h00, 0, "R10");

        checks++;
        if (err_seen != err_exp) begin
            failures++;
            $display("FAIL R4: stuff_err pulses actual=%0d expected=%0d", err_seen, err_exp);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule